// File: doc/BRIEF.md
# Thread Event Unit with Trigger Routing and Kick Counters

This block collects system events for a group of hardware threads and presents them to each thread at one of two handling levels. The background level is a wait-for-event signal that a thread polls or sleeps on at no cost. The interrupt level is a plain request line for a conventional interrupt controller, which is outside this block. Events come from two kinds of source. Hardware triggers are level flags from timers or external logic. Kicks are software events, each delivered as a single write that names a thread.

A configuration port holds two routing masks per thread, one per level. Each mask has one bit per trigger, and a trigger reaches a thread at a level only when the matching bit is set. Each thread also owns a saturating kick counter. The counter is built as a small state machine with three states: `KC_IDLE` (count zero), `KC_PEND` (count between one and the maximum) and `KC_FULL` (count at the maximum). Its transitions are: `T_FIRST` (kick in `KC_IDLE`), `T_ADD` (kick in `KC_PEND` that stays below the maximum), `T_FILL` (kick in `KC_PEND` that reaches the maximum), `T_TAKE` (acknowledge in `KC_PEND` leaving a non-zero count), `T_DRAIN` (acknowledge in `KC_PEND` from a count of one to zero), `T_UNFILL` (acknowledge in `KC_FULL`) and `T_HOLD` (every other case). Software uses the counter as a request queue. The thread consumes one request for each acknowledge. A per-thread mode bit sends a non-zero count to the background or the interrupt output.

Top module: `tev_event_unit`

## Requirements
- R1: After reset all routing masks, mode bits and kick counts are zero, and `bg_event` and `irq_req` are low.
- R2: `cfg_addr` 2*t+l selects the routing mask of thread t at level l (l=0 background, l=1 interrupt). Address 2*N_THREADS holds the mode bits in bits [N_THREADS-1:0]. Addresses 2*N_THREADS+1+t read the kick count of thread t in bits [CNT_W-1:0] and ignore writes. Higher addresses read zero and ignore writes. `cfg_rdata` shows the addressed register combinationally, and a write takes effect at the next clock edge.
- R3: `bg_event[t]` is high in the cycle after a trigger input is sampled high when that trigger's bit is set in thread t's background mask. Without such a trigger and without a background-routed kick, it is low.
- R4: `irq_req[t]` follows the same rule using thread t's interrupt mask.
- R5: A kick (`kick_valid` with `kick_tid`=t) without an acknowledge increments thread t's count by one. A kick leaves the other threads' counts unchanged.
- R6: An acknowledge on `kick_ack[t]` without a kick for t decrements a non-zero count by exactly one.
- R7: A kick and an acknowledge for the same thread in the same cycle leave a non-zero count unchanged. From a count of zero they give a count of one.
- R8: The count saturates at 2**CNT_W-1, and further kicks leave it there. An acknowledge while the count is zero has no effect.
- R9: While thread t's count is non-zero, the thread's kick event is asserted on `bg_event[t]` if mode bit t is 0, and on `irq_req[t]` if it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | N_TRIG (8) | Hardware trigger level flags |
| kick_valid | input | 1 | One kick this cycle |
| kick_tid | input | TID_W (2) | Thread receiving the kick |
| kick_ack | input | N_THREADS (4) | Per-thread kick acknowledge |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (4) | Configuration register address |
| cfg_wdata | input | N_TRIG (8) | Configuration write data |
| cfg_rdata | output | N_TRIG (8) | Configuration read data |
| bg_event | output | N_THREADS (4) | Per-thread background event |
| irq_req | output | N_THREADS (4) | Per-thread interrupt request |

## Verification
On every cycle the assertions check the counter arithmetic: increment, the single-step decrement, the hold when a kick and an acknowledge coincide, saturation and the ignored acknowledge at zero. They also check the routing rule from registered triggers and masks to both outputs. The register address map, the readback of counts, the one-cycle trigger latency and the isolation between threads are shown by the bench's scenarios. In those scenarios a behavioural model is compared against the outputs on each clock.

// File: rtl/tev_pkg.sv
package tev_pkg;

    // Kick counter occupancy states
    typedef enum logic [1:0] {
        KC_IDLE = 2'd0,
        KC_PEND = 2'd1,
        KC_FULL = 2'd2
    } kc_state_e;

    localparam int LVL_BG  = 0;
    localparam int LVL_IRQ = 1;
    localparam int N_LVL   = 2;

endpackage

// File: rtl/tev_kick_ctr.sv
module tev_kick_ctr
    import tev_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pend_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam bit               MAX_IS_ONE = (CNT_W == 1);

    kc_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            KC_IDLE: begin
                // T_FIRST: acknowledge is meaningless at zero
                if (kick_i) begin
                    cnt_d   = CNT_ONE;
                    state_d = MAX_IS_ONE ? KC_FULL : KC_PEND;
                end
            end
            KC_PEND: begin
                if (kick_i && !ack_i) begin
                    cnt_d   = cnt_q + CNT_ONE;          // T_ADD / T_FILL
                    state_d = (cnt_q + CNT_ONE == CNT_MAX) ? KC_FULL : KC_PEND;
                end else if (ack_i && !kick_i) begin
                    cnt_d   = cnt_q - CNT_ONE;          // T_TAKE / T_DRAIN
                    state_d = (cnt_q == CNT_ONE) ? KC_IDLE : KC_PEND;
                end
                // T_HOLD otherwise
            end
            KC_FULL: begin
                if (ack_i && !kick_i) begin
                    cnt_d   = cnt_q - CNT_ONE;          // T_UNFILL
                    state_d = MAX_IS_ONE ? KC_IDLE : KC_PEND;
                end
                // T_HOLD: saturated kick or kick with acknowledge
            end
            default: begin
                state_d = KC_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        cnt_o  = cnt_q;
        pend_o = (state_q != KC_IDLE);
    end

endmodule

// File: rtl/tev_cfg_file.sv
module tev_cfg_file
    import tev_pkg::*;
#(
    parameter int N_THR  = 4,
    parameter int N_TRIG = 8,
    parameter int CNT_W  = 3,
    parameter int AW     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [N_TRIG-1:0]             wdata,
    input  logic [N_THR-1:0][CNT_W-1:0]   cnt_i,
    output logic [N_TRIG-1:0]             rdata,
    output logic [N_THR-1:0][N_TRIG-1:0]  route_bg_o,
    output logic [N_THR-1:0][N_TRIG-1:0]  route_irq_o,
    output logic [N_THR-1:0]              mode_o
);

    localparam int N_MASK    = N_LVL * N_THR;
    localparam int ADDR_MODE = N_MASK;
    localparam int ADDR_CNT0 = N_MASK + 1;

    logic [N_MASK-1:0][N_TRIG-1:0] mask_q;
    logic [N_THR-1:0]              mode_q;

    // one register per routing mask
    for (genvar g = 0; g < N_MASK; g++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_q[g] <= '0;
            else if (wr_en && addr == AW'(g))
                mask_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_en && addr == AW'(ADDR_MODE))
            mode_q <= wdata[N_THR-1:0];
    end

    for (genvar t = 0; t < N_THR; t++) begin : g_route
        assign route_bg_o[t]  = mask_q[N_LVL*t + LVL_BG];
        assign route_irq_o[t] = mask_q[N_LVL*t + LVL_IRQ];
    end
    assign mode_o = mode_q;

    // read mux
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_MASK; i++) begin
            if (addr == AW'(i))
                rdata = mask_q[i];
        end
        if (addr == AW'(ADDR_MODE))
            rdata[N_THR-1:0] = mode_q;
        for (int t = 0; t < N_THR; t++) begin
            if (addr == AW'(ADDR_CNT0 + t))
                rdata[CNT_W-1:0] = cnt_i[t];
        end
    end

endmodule

// File: rtl/tev_level_mux.sv
module tev_level_mux #(
    parameter int N_THR  = 4,
    parameter int N_TRIG = 8
) (
    input  logic [N_TRIG-1:0]            trig_q,
    input  logic [N_THR-1:0][N_TRIG-1:0] route_bg,
    input  logic [N_THR-1:0][N_TRIG-1:0] route_irq,
    input  logic [N_THR-1:0]             mode,
    input  logic [N_THR-1:0]             pend,
    output logic [N_THR-1:0]             bg_event,
    output logic [N_THR-1:0]             irq_req
);

    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        assign bg_event[t] = (|(trig_q & route_bg[t]))  | (pend[t] & ~mode[t]);
        assign irq_req[t]  = (|(trig_q & route_irq[t])) | (pend[t] &  mode[t]);
    end

endmodule

// File: rtl/tev_event_unit.sv
module tev_event_unit #(
    parameter int N_THREADS = 4,
    parameter int N_TRIG    = 8,
    parameter int CNT_W     = 3,
    localparam int TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
    localparam int AW       = $clog2(3 * N_THREADS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_TRIG-1:0]    trig_in,
    input  logic                 kick_valid,
    input  logic [TID_W-1:0]     kick_tid,
    input  logic [N_THREADS-1:0] kick_ack,
    input  logic                 cfg_wr_en,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [N_TRIG-1:0]    cfg_wdata,
    output logic [N_TRIG-1:0]    cfg_rdata,
    output logic [N_THREADS-1:0] bg_event,
    output logic [N_THREADS-1:0] irq_req
);

    logic [N_TRIG-1:0]                   trig_q;
    logic [N_THREADS-1:0]                kick_hit;
    logic [N_THREADS-1:0]                pend;
    logic [N_THREADS-1:0][CNT_W-1:0]     cnt_all;
    logic [N_THREADS-1:0][N_TRIG-1:0]    route_bg;
    logic [N_THREADS-1:0][N_TRIG-1:0]    route_irq;
    logic [N_THREADS-1:0]                mode_q;

    // trigger sampling stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            trig_q <= '0;
        else
            trig_q <= trig_in;
    end

    for (genvar t = 0; t < N_THREADS; t++) begin : g_kick
        assign kick_hit[t] = kick_valid && (kick_tid == TID_W'(t));

        tev_kick_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .kick_i (kick_hit[t]),
            .ack_i  (kick_ack[t]),
            .cnt_o  (cnt_all[t]),
            .pend_o (pend[t])
        );
    end

    tev_cfg_file #(
        .N_THR  (N_THREADS),
        .N_TRIG (N_TRIG),
        .CNT_W  (CNT_W),
        .AW     (AW)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .cnt_i       (cnt_all),
        .rdata       (cfg_rdata),
        .route_bg_o  (route_bg),
        .route_irq_o (route_irq),
        .mode_o      (mode_q)
    );

    tev_level_mux #(
        .N_THR  (N_THREADS),
        .N_TRIG (N_TRIG)
    ) u_mux (
        .trig_q    (trig_q),
        .route_bg  (route_bg),
        .route_irq (route_irq),
        .mode      (mode_q),
        .pend      (pend),
        .bg_event  (bg_event),
        .irq_req   (irq_req)
    );

endmodule

// File: rtl/tev_event_unit_chk.sv
module tev_event_unit_chk #(
    parameter int N_THREADS = 4,
    parameter int N_TRIG    = 8,
    parameter int CNT_W     = 3,
    parameter int TID_W     = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              kick_valid,
    input logic [TID_W-1:0]                  kick_tid,
    input logic [N_THREADS-1:0]              kick_ack,
    input logic [N_THREADS-1:0][CNT_W-1:0]   cnt_all,
    input logic [N_TRIG-1:0]                 trig_q,
    input logic [N_THREADS-1:0][N_TRIG-1:0]  route_bg,
    input logic [N_THREADS-1:0][N_TRIG-1:0]  route_irq,
    input logic [N_THREADS-1:0]              mode_q,
    input logic [N_THREADS-1:0]              bg_event,
    input logic [N_THREADS-1:0]              irq_req
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
        logic hit;
        assign hit = kick_valid && (kick_tid == TID_W'(t));

        AST_KICK_INC: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !kick_ack[t] && cnt_all[t] != CMAX) |=> cnt_all[t] == $past(cnt_all[t]) + CNT_W'(1)); // R5
        AST_ACK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
            (kick_ack[t] && !hit && cnt_all[t] != '0) |=> cnt_all[t] == $past(cnt_all[t]) - CNT_W'(1)); // R6
        AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (kick_ack[t] && hit && cnt_all[t] != '0) |=> $stable(cnt_all[t])); // R7
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_all[t] == CMAX && hit) |=> cnt_all[t] == CMAX || kick_ack[t] == 1'b0 && 1'b0); // R8
        AST_ZERO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_all[t] == '0 && kick_ack[t] && !hit) |=> cnt_all[t] == '0); // R8
        AST_BG_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            (|(trig_q & route_bg[t])) |-> bg_event[t]); // R3
        AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            (|(trig_q & route_irq[t])) |-> irq_req[t]); // R4
        AST_BG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!(|(trig_q & route_bg[t])) && (cnt_all[t] == '0 || mode_q[t])) |-> !bg_event[t]); // R3
        AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!(|(trig_q & route_irq[t])) && (cnt_all[t] == '0 || !mode_q[t])) |-> !irq_req[t]); // R4
        AST_KICK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_all[t] != '0) |-> (mode_q[t] ? irq_req[t] : bg_event[t])); // R9
    end

endmodule

bind tev_event_unit tev_event_unit_chk #(
    .N_THREADS (N_THREADS),
    .N_TRIG    (N_TRIG),
    .CNT_W     (CNT_W),
    .TID_W     (TID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick_valid (kick_valid),
    .kick_tid   (kick_tid),
    .kick_ack   (kick_ack),
    .cnt_all    (cnt_all),
    .trig_q     (trig_q),
    .route_bg   (route_bg),
    .route_irq  (route_irq),
    .mode_q     (mode_q),
    .bg_event   (bg_event),
    .irq_req    (irq_req)
);

// File: tb/tev_event_unit_tb.sv
`timescale 1ns/1ps
module tev_event_unit_tb;

    localparam int NT = 4;
    localparam int NG = 8;
    localparam int CW = 3;
    localparam int CMAX = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG-1:0] trig_in = '0;
    logic          kick_valid = 1'b0;
    logic [1:0]    kick_tid = '0;
    logic [NT-1:0] kick_ack = '0;
    logic          cfg_wr_en = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [NG-1:0] cfg_wdata = '0;
    logic [NG-1:0] cfg_rdata;
    logic [NT-1:0] bg_event;
    logic [NT-1:0] irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_mask [8];
    int m_mode;
    int m_cnt  [NT];
    int m_trig;

    always #2.5 clk = ~clk;

    tev_event_unit #(.N_THREADS(NT), .N_TRIG(NG), .CNT_W(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .kick_valid (kick_valid),
        .kick_tid   (kick_tid),
        .kick_ack   (kick_ack),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .bg_event   (bg_event),
        .irq_req    (irq_req)
    );

    function automatic int mread(int a);
        if (a < 8)  return m_mask[a];
        if (a == 8) return m_mode;
        if (a >= 9 && a <= 12) return m_cnt[a - 9];
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_mask[i] = 0;
        for (int t = 0; t < NT; t++) m_cnt[t] = 0;
        m_mode = 0;
        m_trig = 0;
    endtask

    task automatic model_step();
        if (cfg_wr_en) begin
            if (cfg_addr < 8) m_mask[cfg_addr] = cfg_wdata;
            else if (cfg_addr == 8) m_mode = cfg_wdata & 'hF;
        end
        for (int t = 0; t < NT; t++) begin
            bit k = kick_valid && (kick_tid == t);
            bit a = kick_ack[t];
            if (m_cnt[t] == 0) begin
                if (k) m_cnt[t] = 1;
            end else if (k && !a) begin
                if (m_cnt[t] < CMAX) m_cnt[t]++;
            end else if (a && !k) begin
                m_cnt[t]--;
            end
        end
        m_trig = trig_in;
    endtask

    task automatic compare(string tag);
        logic [NT-1:0] ebg, eirq;
        logic [NG-1:0] erd;
        for (int t = 0; t < NT; t++) begin
            ebg[t]  = ((m_trig & m_mask[2*t])   != 0) || (m_cnt[t] != 0 && !m_mode[t]);
            eirq[t] = ((m_trig & m_mask[2*t+1]) != 0) || (m_cnt[t] != 0 &&  m_mode[t]);
        end
        erd = NG'(mread(cfg_addr));
        checks++;
        if (bg_event !== ebg) begin
            errors++;
            $display("FAIL %s bg_event actual=%b expected=%b", tag, bg_event, ebg);
        end
        if (irq_req !== eirq) begin
            errors++;
            $display("FAIL %s irq_req actual=%b expected=%b", tag, irq_req, eirq);
        end
        if (cfg_rdata !== erd) begin
            errors++;
            $display("FAIL %s cfg_rdata@%0d actual=%h expected=%h", tag, cfg_addr, cfg_rdata, erd);
        end
    endtask

    // one clock: apply inputs, model the edge, sample at the next falling edge
    task automatic cyc(string tag, logic [NG-1:0] trg, logic kv, logic [1:0] tid,
                       logic [NT-1:0] ack, logic we, logic [3:0] ad, logic [NG-1:0] wd);
        trig_in = trg; kick_valid = kv; kick_tid = tid; kick_ack = ack;
        cfg_wr_en = we; cfg_addr = ad; cfg_wdata = wd;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle_read(string tag, logic [3:0] ad);
        cyc(tag, m_trig[NG-1:0], 1'b0, 2'd0, '0, 1'b0, ad, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: state during reset
        compare("R1");
        rst_n = 1'b1;
        for (int a = 8; a <= 12; a++) idle_read("R1", 4'(a));

        // R2: register map write and readback, out-of-range ignored
        for (int a = 0; a < 9; a++) cyc("R2", '0, 1'b0, 2'd0, '0, 1'b1, 4'(a), NG'(8'h11 * (a + 1)));
        for (int a = 0; a < 16; a++) idle_read("R2", 4'(a));
        cyc("R2", '0, 1'b0, 2'd0, '0, 1'b1, 4'd9,  8'hFF);
        cyc("R2", '0, 1'b0, 2'd0, '0, 1'b1, 4'd14, 8'hFF);
        for (int a = 9; a < 16; a++) idle_read("R2", 4'(a));
        for (int a = 0; a < 9; a++) idle_read("R2", 4'(a));

        // R3/R4: clear masks, then single-trigger routing
        for (int a = 0; a < 9; a++) cyc("R3", '0, 1'b0, 2'd0, '0, 1'b1, 4'(a), '0);
        cyc("R3", '0, 1'b0, 2'd0, '0, 1'b1, 4'd2, 8'h04);   // thread 1 background: trigger 2
        cyc("R4", '0, 1'b0, 2'd0, '0, 1'b1, 4'd7, 8'h80);   // thread 3 interrupt: trigger 7
        cyc("R3", 8'h04, 1'b0, 2'd0, '0, 1'b0, 4'd0, '0);
        cyc("R3", 8'h7B, 1'b0, 2'd0, '0, 1'b0, 4'd0, '0);   // unrouted triggers
        cyc("R4", 8'h80, 1'b0, 2'd0, '0, 1'b0, 4'd0, '0);
        cyc("R4", 8'h84, 1'b0, 2'd0, '0, 1'b0, 4'd0, '0);
        cyc("R4", 8'h00, 1'b0, 2'd0, '0, 1'b0, 4'd0, '0);

        // R5/R9: kicks on thread 0 (background) and thread 2 (interrupt)
        cyc("R9", '0, 1'b0, 2'd0, '0, 1'b1, 4'd8, 8'h04);
        for (int i = 0; i < 3; i++) cyc("R5", '0, 1'b1, 2'd0, '0, 1'b0, 4'd9, '0);
        cyc("R5", '0, 1'b1, 2'd2, '0, 1'b0, 4'd11, '0);
        idle_read("R5", 4'd9);
        idle_read("R9", 4'd10);

        // R6: acknowledges drain thread 0 one at a time
        for (int i = 0; i < 3; i++) cyc("R6", '0, 1'b0, 2'd0, 4'b0001, 1'b0, 4'd9, '0);
        // R8: acknowledge at zero has no effect
        cyc("R8", '0, 1'b0, 2'd0, 4'b0001, 1'b0, 4'd9, '0);
        // R7: kick plus acknowledge at zero gives one, at non-zero holds
        cyc("R7", '0, 1'b1, 2'd0, 4'b0001, 1'b0, 4'd9, '0);
        cyc("R7", '0, 1'b1, 2'd0, 4'b0001, 1'b0, 4'd9, '0);
        // R8: saturation
        for (int i = 0; i < 10; i++) cyc("R8", '0, 1'b1, 2'd1, '0, 1'b0, 4'd10, '0);
        cyc("R8", '0, 1'b1, 2'd1, 4'b0010, 1'b0, 4'd10, '0);
        cyc("R8", '0, 1'b0, 2'd1, 4'b0010, 1'b0, 4'd10, '0);

        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [NT-1:0] ack;
            ack = NT'($urandom) & NT'($urandom);
            cyc("R3/R4/R5/R6/R7/R8/R9", NG'($urandom) & NG'($urandom), 1'($urandom), 2'($urandom),
                ack, ($urandom % 8) == 0, 4'($urandom), NG'($urandom));
        end

        finish_run();
    end

endmodule